// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This peripheral holds an 8-bit up-counter and an 8-bit control/status register behind a small memory-mapped bus. The bus carries a byte offset, 32-bit write data and a transfer-size code. Software can change either register only with a 16-bit transfer whose high byte carries the key that belongs to that register. The low byte of such a transfer becomes the new register value. Every other write is dropped without any sign. This protects a running watchdog against stray stores. Stray stores include byte and 32-bit accesses, and correctly sized accesses that carry the other register's key.

When the enable bit is set, a free-running prescaler produces a count tick every 2^(sel+1) clocks, and the counter advances on each tick. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set and a one-clock timeout pulse is issued. Software clears the flag with a keyed control/status write that has bit 7 at zero. Reads need no key. A read returns the register value zero-extended.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the counter and the control/status register both read 0x00, timeoutPulse is low, and the counter does not advance.
- R2: A write with busSize = 1 (word) at offset 0x0 and 0x5A in busWData[15:8] loads busWData[7:0] into the counter; busWData[31:16] are ignored.
- R3: A word write at offset 0x2 with 0xA5 in busWData[15:8] loads busWData[6:0] into control/status bits 6:0 (bit 5 = enable, bits 2:0 = prescale select).
- R4: Writes with busSize = 0 (byte) or busSize = 2 (32-bit) leave both registers unchanged whatever key they carry.
- R5: A word write whose key is not the key of the addressed register (including the other register's key), or a write to any offset other than 0x0 and 0x2, changes nothing.
- R6: A read with busSize 0 or 1 at offset 0x0 or 0x2 returns the register zero-extended to 32 bits, and control/status bit 7 is the overflow flag; a 32-bit read or a read at any other offset returns 0.
- R7: While enable is set, the counter increments once every 2^(sel+1) clocks, and the first increment comes 2^(sel+1) clocks after the enabling write. While enable is clear, the counter holds and the prescaler is held at zero.
- R8: A wrap from 0xFF to 0x00 sets the overflow flag and raises timeoutPulse for exactly one clock, in the same cycle that the counter first reads 0x00.
- R9: The overflow flag stays set until a keyed control/status write with bit 7 = 0; a keyed write with bit 7 = 1 neither clears nor sets it.
- R10: When a wrap and a flag-clearing control/status write land on the same clock edge, the flag ends up set.
- R11: When a keyed counter write lands on the same clock edge as a count tick, the written value is loaded, with no increment and no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset within the block window |
| busWrEn | input | 1 | Write strobe, one cycle per transfer |
| busRdEn | input | 1 | Read strobe |
| busSize | input | 2 | Transfer size: 0 byte, 1 word, 2 32-bit |
| busWData | input | 32 | Write data; key in bits 15:8, value in bits 7:0 |
| busRData | output | 32 | Combinational read data |
| timeoutPulse | output | 1 | One-clock pulse on counter wrap |

## Verification
Two events can land on the same clock edge. One is the counter wrap, which sets the overflow flag. The other is a keyed control/status write with bit 7 at zero, which tries to clear the flag. The bench arranges this by loading the counter with 0xFF, enabling the fastest prescale, and timing a second control/status write onto the edge of the first tick. It then expects the timeout pulse, a counter value of 0x00 and a status value of 0xA0 in the same cycle, and expects the flag to clear only on the next such write. The same timing technique places a counter write on a tick edge, where the written value must win.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int REG_W    = 8;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int SEL_W    = 3;
  localparam int PRE_W    = 1 << SEL_W;
  localparam int KEY_LSB  = 8;
  localparam int EN_BIT   = 5;
  localparam int FLAG_BIT = REG_W - 1;

  localparam logic [ADDR_W-1:0] CNT_OFS = 4'h0;
  localparam logic [ADDR_W-1:0] CSR_OFS = 4'h2;
  localparam logic [7:0]        CNT_KEY = 8'h5A;
  localparam logic [7:0]        CSR_KEY = 8'hA5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic             wrCnt;
    logic             wrCsr;
    logic [REG_W-1:0] wrVal;
  } strobe_t;
endpackage

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  input  logic [BUS_W-1:0]  busWData,
  input  logic [REG_W-1:0]  cntVal,
  input  logic [REG_W-1:0]  csrVal,
  output strobe_t           strb,
  output logic [BUS_W-1:0]  busRData
);
  logic       isWord;
  logic       rdSizeOk;
  logic       hitCnt;
  logic       hitCsr;
  logic [7:0] keyByte;
  logic       unusedHi;

  assign unusedHi = ^busWData[BUS_W-1:KEY_LSB+8];

  always_comb begin
    isWord   = (busSize == SZ_WORD);
    rdSizeOk = (busSize == SZ_WORD) || (busSize == SZ_BYTE);
    hitCnt   = (busAddr == CNT_OFS);
    hitCsr   = (busAddr == CSR_OFS);
    keyByte  = busWData[KEY_LSB +: 8];
  end

  // Key gate: word size, matching offset, and the key owned by that offset
  always_comb begin
    strb.wrCnt = busWrEn && isWord && hitCnt && (keyByte == CNT_KEY);
    strb.wrCsr = busWrEn && isWord && hitCsr && (keyByte == CSR_KEY);
    strb.wrVal = busWData[REG_W-1:0];
  end

  always_comb begin
    busRData = '0;
    if (busRdEn && rdSizeOk) begin
      if (hitCnt)      busRData[REG_W-1:0] = cntVal;
      else if (hitCsr) busRData[REG_W-1:0] = csrVal;
    end
  end
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [REG_W-1:0] cntVal,
  output logic [REG_W-1:0] csrVal,
  output logic             timeoutPulse
);
  logic [REG_W-1:0]    cntQ;
  logic [FLAG_BIT-1:0] csrLoQ;
  logic                flagQ;
  logic [PRE_W-1:0]    preQ;
  logic                toQ;
  logic [PRE_W-1:0]    mask;
  logic [SEL_W-1:0]    sel;
  logic                en;
  logic                tick;
  logic                wrap;

  assign en  = csrLoQ[EN_BIT];
  assign sel = csrLoQ[SEL_W-1:0];

  // Prescale mask: low (sel+1) bits set
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (32'(i) <= 32'(sel));
  end

  always_comb begin
    tick = en && ((preQ & mask) == mask);
    wrap = tick && !strb.wrCnt && (cntQ == '1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      csrLoQ <= '0;
      flagQ  <= 1'b0;
      preQ   <= '0;
      toQ    <= 1'b0;
    end else begin
      preQ <= en ? preQ + PRE_W'(1) : '0;
      toQ  <= wrap;
      if (strb.wrCnt)  cntQ <= strb.wrVal;
      else if (tick)   cntQ <= cntQ + REG_W'(1);
      if (strb.wrCsr)  csrLoQ <= strb.wrVal[FLAG_BIT-1:0];
      if (wrap)                                     flagQ <= 1'b1;
      else if (strb.wrCsr && !strb.wrVal[FLAG_BIT]) flagQ <= 1'b0;
    end
  end

  assign cntVal       = cntQ;
  assign csrVal       = {flagQ, csrLoQ};
  assign timeoutPulse = toQ;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  input  logic [BUS_W-1:0]  busWData,
  output logic [BUS_W-1:0]  busRData,
  output logic              timeoutPulse
);
  strobe_t          strb;
  logic [REG_W-1:0] cntVal;
  logic [REG_W-1:0] csrVal;

  keyed_wdog_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busSize (busSize),
    .busWData(busWData),
    .cntVal  (cntVal),
    .csrVal  (csrVal),
    .strb    (strb),
    .busRData(busRData)
  );

  keyed_wdog_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cntVal      (cntVal),
    .csrVal      (csrVal),
    .timeoutPulse(timeoutPulse)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [1:0]        busSize,
  input logic [BUS_W-1:0]  busWData,
  input logic              timeoutPulse,
  input strobe_t           strb,
  input logic [REG_W-1:0]  cntVal,
  input logic [REG_W-1:0]  csrVal
);
  AST_BAD_SIZE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSize != SZ_WORD) |-> (!strb.wrCnt && !strb.wrCsr)); // R4

  AST_WRONG_KEY_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busWData[KEY_LSB +: 8] != CNT_KEY) |-> !strb.wrCnt); // R5

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCnt && !csrVal[EN_BIT]) |=> $stable(cntVal)); // R7

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCnt && csrVal[EN_BIT]) |=>
      (cntVal == $past(cntVal) || cntVal == $past(cntVal) + 8'd1)); // R7

  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse); // R8

  AST_TIMEOUT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (cntVal == '0 && csrVal[FLAG_BIT])); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (csrVal[FLAG_BIT] && !strb.wrCsr) |=> csrVal[FLAG_BIT]); // R9
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .busSize     (busSize),
  .busWData    (busWData),
  .timeoutPulse(timeoutPulse),
  .strb        (strb),
  .cntVal      (cntVal),
  .csrVal      (csrVal)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        timeoutPulse;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busSize(busSize), .busWData(busWData),
    .busRData(busRData), .timeoutPulse(timeoutPulse)
  );

  localparam int NV = 13;
  // {size[1:0], addr[3:0], data[31:0], expCnt[7:0], expCsr[7:0]}
  localparam logic [53:0] VEC [0:NV-1] = '{
    {2'd1, 4'h0, 32'h0000_5A37, 8'h37, 8'h00},
    {2'd0, 4'h0, 32'h0000_5A11, 8'h37, 8'h00},
    {2'd2, 4'h0, 32'h0000_5A22, 8'h37, 8'h00},
    {2'd1, 4'h0, 32'h0000_A544, 8'h37, 8'h00},
    {2'd1, 4'h2, 32'h0000_A507, 8'h37, 8'h07},
    {2'd1, 4'h2, 32'h0000_5A03, 8'h37, 8'h07},
    {2'd0, 4'h2, 32'h0000_A501, 8'h37, 8'h07},
    {2'd2, 4'h2, 32'h1234_A51C, 8'h37, 8'h07},
    {2'd1, 4'h2, 32'h0000_A55C, 8'h37, 8'h5C},
    {2'd1, 4'h0, 32'h0000_5B99, 8'h37, 8'h5C},
    {2'd1, 4'h4, 32'h0000_5A66, 8'h37, 8'h5C},
    {2'd1, 4'h2, 32'h0000_A580, 8'h37, 8'h00},
    {2'd1, 4'h0, 32'hFFFF_5AFF, 8'hFF, 8'h00}
  };
  localparam string VTAG [0:NV-1] = '{
    "R2", "R4", "R4", "R5", "R3", "R5", "R4", "R4", "R3", "R5", "R5", "R9", "R2"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; lands on the next rising edge
  task automatic doWrite(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busSize = sz; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWData = '0;
  endtask

  task automatic doRead(input logic [1:0] sz, input logic [3:0] a, output logic [31:0] v);
    busRdEn = 1'b1; busSize = sz; busAddr = a;
    #1;
    v = busRData;
    busRdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and stopped counter
    doRead(2'd1, 4'h0, v); check("R1 counter after reset", v, 32'h0);
    doRead(2'd1, 4'h2, v); check("R1 status after reset", v, 32'h0);
    check("R1 timeout low", {31'b0, timeoutPulse}, 32'h0);
    repeat (6) @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R1 counter stopped", v, 32'h0);

    // Table of keyed / unkeyed writes with counter disabled
    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][53:52], VEC[i][51:48], VEC[i][47:16]);
      doRead(2'd1, 4'h0, v); check($sformatf("%s vec %0d counter", VTAG[i], i), v, {24'h0, VEC[i][15:8]});
      doRead(2'd1, 4'h2, v); check($sformatf("%s vec %0d status", VTAG[i], i), v, {24'h0, VEC[i][7:0]});
    end

    // R6 read sizes and offsets (counter holds 0xFF)
    doRead(2'd0, 4'h0, v); check("R6 byte read", v, 32'h0000_00FF);
    doRead(2'd2, 4'h0, v); check("R6 long read", v, 32'h0);
    doRead(2'd1, 4'h4, v); check("R6 unmapped read", v, 32'h0);

    // R8 wrap: enable, divide by 2; first tick two edges later
    doWrite(2'd1, 4'h2, 32'h0000_A520);
    @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R8 pre-wrap counter", v, 32'h0000_00FF);
    check("R8 pre-wrap timeout", {31'b0, timeoutPulse}, 32'h0);
    @(negedge clk);
    check("R8 timeout pulse", {31'b0, timeoutPulse}, 32'h1);
    doRead(2'd1, 4'h0, v); check("R8 counter wrapped", v, 32'h0);
    doRead(2'd1, 4'h2, v); check("R8 flag set", v, 32'h0000_00A0);
    @(negedge clk);
    check("R8 pulse one clock", {31'b0, timeoutPulse}, 32'h0);

    // R9 write 1 keeps flag, write 0 clears
    doWrite(2'd1, 4'h2, 32'h0000_A5A0);
    doRead(2'd1, 4'h2, v); check("R9 write one keeps flag", v, 32'h0000_00A0);
    doWrite(2'd1, 4'h2, 32'h0000_A500);
    doRead(2'd1, 4'h2, v); check("R9 write zero clears", v, 32'h0);

    // R7 divide by 8
    doWrite(2'd1, 4'h0, 32'h0000_5A00);
    doWrite(2'd1, 4'h2, 32'h0000_A522);
    repeat (7) @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R7 before first tick", v, 32'h0);
    @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R7 first tick", v, 32'h1);
    repeat (8) @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R7 second tick", v, 32'h2);
    doWrite(2'd1, 4'h2, 32'h0000_A502);
    repeat (20) @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R7 disabled hold", v, 32'h2);

    // R11 counter write on a tick edge
    doWrite(2'd1, 4'h0, 32'h0000_5A10);
    doWrite(2'd1, 4'h2, 32'h0000_A520);
    @(negedge clk);
    doWrite(2'd1, 4'h0, 32'h0000_5A40);
    doRead(2'd1, 4'h0, v); check("R11 write beats tick", v, 32'h40);
    @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R11 hold between ticks", v, 32'h40);
    @(negedge clk);
    doRead(2'd1, 4'h0, v); check("R11 next tick", v, 32'h41);
    doWrite(2'd1, 4'h2, 32'h0000_A500);

    // R10 wrap and clearing write on the same edge
    doWrite(2'd1, 4'h0, 32'h0000_5AFF);
    doWrite(2'd1, 4'h2, 32'h0000_A520);
    @(negedge clk);
    doWrite(2'd1, 4'h2, 32'h0000_A520);
    check("R10 timeout on coincident edge", {31'b0, timeoutPulse}, 32'h1);
    doRead(2'd1, 4'h0, v); check("R10 counter wrapped", v, 32'h0);
    doRead(2'd1, 4'h2, v); check("R10 set wins over clear", v, 32'h0000_00A0);
    doWrite(2'd1, 4'h2, 32'h0000_A520);
    doRead(2'd1, 4'h2, v); check("R9 later clear", v, 32'h0000_0020);
    doWrite(2'd1, 4'h2, 32'h0000_A500);

    finishRun();
  end
endmodule